// File: doc/BRIEF.md
# Sinusoidal PWM Generator

This block turns a frequency setting into a pulse-width-modulated bit stream whose duty cycle follows a sine wave. A phase register adds a tuning word every enabled clock. The top bits of that phase select one point of a single sine period, which is computed at elaboration and folded from a quarter-wave table. Once per carrier period that point is captured and compared with an 8-bit sawtooth carrier. The output bit is driven high on every clock where the carrier is above the captured sample.

With a 50 MHz clock, a tuning word `fcw` gives a sine frequency of `fcw * 50e6 / 2^24` Hz. The carrier period is fixed at 256 clocks. The output is intended to drive an external low-pass filter or a power stage. The reset is synchronous and active low. The enable input freezes the whole block and forces the output low.

Top module: `snpwm_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the phase and carrier are cleared to 0. After that edge `sample` reads 128 and `pwm` reads 0.
- R2: Each enabled clock adds `fcw` to a 24-bit phase register modulo 2^24, with no saturation. A `fcw` of 0 keeps the phase constant, and a `fcw` of 2^24-64 steps the phase backwards.
- R3: The carrier is an 8-bit count that steps by one on each enabled clock and wraps from 255 to 0. One carrier period is 256 enabled clocks.
- R4: `sample` changes only at an enabled edge where the carrier is 255. At that edge it takes the table value addressed by phase bits [23:14], using the phase held before that edge.
- R5: Table entry k (0..1023) equals 128 + m for k < 512 and 128 - m otherwise. Here m = floor(127*|sin(2*pi*k/1024)| + 0.5). Every entry therefore lies in the range 1..255.
- R6: After each enabled edge, `pwm` is 1 exactly when the carrier value before that edge was greater than the `sample` value before that edge. Within a carrier period where the sample is constant s, `pwm` is high for 255 - s clocks.
- R7: When `en` is low at an edge, the phase, the carrier and `sample` keep their values, and `pwm` is 0 after that edge. When `en` returns high, counting resumes from the held values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance enable; low freezes the block and forces `pwm` low |
| fcw | input | 24 | Frequency control word added to the phase each enabled clock |
| sample | output | 8 | Sine sample currently used by the comparator, offset binary |
| pwm | output | 1 | Registered PWM bit, high while the carrier exceeds the sample |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- Quadrant fold points of the sine table (entries 0, 256, 512, 768 and their neighbours). The sweep reaches these across a long run. A fold off by one would return the wrong magnitude there, or select index 257.
- Phase wrap under a negative-going tuning word. The first captured sample must come from entry 1023. A design that saturates or sign-handles the phase would capture 128 or a rising value instead.
- Sample-capture timing. The duty counts at the extreme samples must be exactly 254 and 0 high clocks. A comparator with the opposite sense, a `>=` instead of `>`, or a capture at the wrong carrier value each shifts these counts by one.
- Enable freeze. The output must stay low and the held state must resume without a skipped carrier step.

// File: rtl/snpwm_pkg.sv
// snpwm_pkg: shared types and elaboration-time helpers for the sinusoidal
// PWM generator. Assumes the sine magnitude is evaluated only on constants.
package snpwm_pkg;

    localparam real TWO_PI = 6.28318530717958647692;

    // Quadrant of one sine period, taken from the two top address bits.
    typedef enum logic [1:0] {
        Q_RISE   = 2'd0,
        Q_FALL   = 2'd1,
        Q_DROP   = 2'd2,
        Q_RETURN = 2'd3
    } quad_t;

    // Rounded magnitude amp*sin(2*pi*idx/2^addr_w); used on constants only.
    function automatic int quarter_mag(input int idx, input int addr_w, input int amp);
        real ang;
        real val;
        ang = TWO_PI * real'(idx) / real'(2 ** addr_w);
        val = real'(amp) * $sin(ang);
        return $rtoi($floor(val + 0.5));
    endfunction

endpackage

// File: rtl/snpwm_phase_acc.sv
// snpwm_phase_acc: modulo-2^PHASE_W phase register that integrates the
// frequency control word. Only the top ADDR_W bits leave the module.
// Assumes ADDR_W <= PHASE_W.
module snpwm_phase_acc #(
    parameter int PHASE_W = 24,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PHASE_W-1:0] fcw,
    output logic [ADDR_W-1:0]  addr
);

    logic [PHASE_W-1:0] acc;

    // Integrate the tuning word; wraps naturally at 2^PHASE_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + fcw;
        end
    end

    assign addr = acc[PHASE_W-1 -: ADDR_W];

    AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> $stable(acc)); // R7

    AST_ACC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && ($past(fcw) == '0)) |-> $stable(acc)); // R2

endmodule

// File: rtl/snpwm_sine_rom.sv
// snpwm_sine_rom: one full sine period in offset binary, rebuilt from a
// quarter-wave magnitude table of 2^(ADDR_W-2)+1 entries computed at
// elaboration. Combinational read. Assumes ADDR_W >= 3 and SAMPLE_W >= 2.
module snpwm_sine_rom #(
    parameter int ADDR_W   = 10,
    parameter int SAMPLE_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [SAMPLE_W-1:0] sample
);
    import snpwm_pkg::*;

    localparam int QBITS = ADDR_W - 2;
    localparam int QLEN  = (2 ** QBITS) + 1;
    localparam int MID   = 2 ** (SAMPLE_W - 1);
    localparam int AMP   = MID - 1;
    localparam logic [QBITS:0]      QTOP = QBITS'(0) + (QBITS+1)'(2 ** QBITS);
    localparam logic [SAMPLE_W-1:0] MIDV = SAMPLE_W'(MID);

    logic [SAMPLE_W-2:0] qtab [QLEN];

    // One constant entry per quarter-wave point, endpoint included.
    for (genvar g = 0; g < QLEN; g++) begin : g_qtab
        localparam int MAG = quarter_mag(g, ADDR_W, AMP);
        assign qtab[g] = MAG[SAMPLE_W-2:0];
    end

    quad_t               quad;
    logic [QBITS-1:0]    step;
    logic [QBITS:0]      idx;
    logic [SAMPLE_W-2:0] mag;

    // Fold the address into the quarter table and restore the sign.
    always_comb begin
        quad = quad_t'(addr[ADDR_W-1 -: 2]);
        step = addr[QBITS-1:0];
        if (quad == Q_FALL || quad == Q_RETURN) begin
            idx = QTOP - {1'b0, step};
        end else begin
            idx = {1'b0, step};
        end
        mag = qtab[idx];
        if (quad == Q_DROP || quad == Q_RETURN) begin
            sample = MIDV - {1'b0, mag};
        end else begin
            sample = MIDV + {1'b0, mag};
        end
    end

    // Guard: the folded output never reaches code 0.
    always_comb begin
        AST_ROM_NONZERO: assert (sample != '0); // R5
    end

endmodule

// File: rtl/snpwm_carrier.sv
// snpwm_carrier: free-running sawtooth of CARR_W bits, advancing on enabled
// clocks. Flags the enabled clock on which it wraps to zero.
module snpwm_carrier #(
    parameter int CARR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [CARR_W-1:0] count,
    output logic              wrap
);

    localparam logic [CARR_W-1:0] TOP = '1;

    // Step the sawtooth; rolls over from all-ones to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (en) begin
            count <= count + 1'b1;
        end
    end

    assign wrap = en && (count == TOP);

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && ($past(count) == TOP)) |-> (count == '0)); // R3

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> $stable(count)); // R7

endmodule

// File: rtl/snpwm_pwm_stage.sv
// snpwm_pwm_stage: captures the table sample at each carrier wrap and
// compares it with the carrier. Output is high while carrier > sample.
// Assumes the carrier and the sample have the same width.
module snpwm_pwm_stage #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                wrap,
    input  logic [SAMPLE_W-1:0] count,
    input  logic [SAMPLE_W-1:0] rom_sample,
    output logic [SAMPLE_W-1:0] sample,
    output logic                pwm
);

    localparam logic [SAMPLE_W-1:0] MIDV = SAMPLE_W'(2 ** (SAMPLE_W - 1));

    // Capture a new sample only when the carrier rolls over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= MIDV;
        end else if (wrap) begin
            sample <= rom_sample;
        end
    end

    // Registered compare; forced low while the block is frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else begin
            pwm <= en && (count > sample);
        end
    end

    AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wrap)) |-> $stable(sample)); // R4

    AST_PWM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !pwm); // R7

    AST_PWM_NOT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pwm |-> ($past(count) != '0)); // R6

endmodule

// File: rtl/snpwm_gen.sv
// snpwm_gen: sinusoidal PWM generator. Phase accumulator -> quarter-wave
// sine table -> per-period sample capture -> sawtooth comparator.
// Assumes a synchronous active-low reset and an 8-bit-class carrier whose
// width equals the sample width.
module snpwm_gen #(
    parameter int PHASE_W  = 24,
    parameter int ADDR_W   = 10,
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [PHASE_W-1:0]  fcw,
    output logic [SAMPLE_W-1:0] sample,
    output logic                pwm
);

    localparam logic [SAMPLE_W-1:0] MIDV = SAMPLE_W'(2 ** (SAMPLE_W - 1));

    logic [ADDR_W-1:0]   addr;
    logic [SAMPLE_W-1:0] rom_sample;
    logic [SAMPLE_W-1:0] count;
    logic                wrap;

    snpwm_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .fcw   (fcw),
        .addr  (addr)
    );

    snpwm_sine_rom #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_rom (
        .addr   (addr),
        .sample (rom_sample)
    );

    snpwm_carrier #(.CARR_W(SAMPLE_W)) u_carrier (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .count (count),
        .wrap  (wrap)
    );

    snpwm_pwm_stage #(.SAMPLE_W(SAMPLE_W)) u_pwm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .wrap       (wrap),
        .count      (count),
        .rom_sample (rom_sample),
        .sample     (sample),
        .pwm        (pwm)
    );

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ((sample == MIDV) && !pwm && (count == '0))); // R1

endmodule

// File: tb/snpwm_gen_test.sv
module snpwm_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [23:0] fcw = '0;
    logic [7:0]  sample;
    logic        pwm;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Bench-side model state
    logic [23:0] m_acc;
    int          m_cnt;
    int          m_samp;
    bit          m_pwm;
    bit          m_latched;

    always #2 clk = ~clk;

    snpwm_gen uut (
        .clk(clk), .rst_n(rst_n), .en(en), .fcw(fcw),
        .sample(sample), .pwm(pwm)
    );

    function automatic int exp_tab(input int k);
        real a;
        real s;
        int  m;
        a = 6.28318530717958647692 * real'(k) / 1024.0;
        s = $sin(a);
        if (s < 0.0) s = -s;
        m = $rtoi($floor(127.0 * s + 0.5));
        return (k < 512) ? 128 + m : 128 - m;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at negedge.
    task automatic step(input bit r, input bit e, input logic [23:0] f);
        bit nxt;
        rst_n = r;
        en    = e;
        fcw   = f;
        @(posedge clk);
        m_latched = 1'b0;
        if (!r) begin
            m_acc = '0; m_cnt = 0; m_samp = 128; m_pwm = 1'b0;
        end else begin
            nxt = e && (m_cnt > m_samp);
            if (e && m_cnt == 255) begin
                m_samp = exp_tab(int'(m_acc[23:14]));
                m_latched = 1'b1;
            end
            if (e) begin
                m_acc = m_acc + f;
                m_cnt = (m_cnt + 1) % 256;
            end
            m_pwm = nxt;
        end
        @(negedge clk);
        if (m_latched) begin
            check("R5 table sample", int'(sample), m_samp);
            checks++;
            if (sample == 8'd0) begin
                errors++;
                $display("FAIL R5 range actual=%0d expected=1..255", sample);
            end
        end else begin
            check("R4 sample hold", int'(sample), m_samp);
        end
        check("R6 pwm", int'(pwm), int'(m_pwm));
    endtask

    task automatic do_reset();
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, '0);
    endtask

    task automatic run_to_latch(input logic [23:0] f);
        do step(1'b1, 1'b1, f); while (!m_latched);
    endtask

    task automatic count_high(input logic [23:0] f, output int highs);
        highs = 0;
        for (int i = 0; i < 256; i++) begin
            step(1'b1, 1'b1, f);
            highs += int'(pwm);
        end
    endtask

    initial begin
        int   h;
        logic [7:0] held;
        m_acc = '0; m_cnt = 0; m_samp = 128; m_pwm = 1'b0; m_latched = 1'b0;
        @(negedge clk);

        // R1: reset state
        do_reset();
        check("R1 reset sample", int'(sample), 128);
        check("R1 reset pwm", int'(pwm), 0);

        // R2/R3: fcw=0 keeps midscale; R3 period gives 127 high clocks
        count_high('0, h);
        check("R3 duty at midscale", h, 127);
        count_high('0, h);
        check("R2 zero word duty", h, 127);
        check("R2 zero word sample", int'(sample), 128);

        // R2: negative-going word wraps to entry 1023 first
        do_reset();
        run_to_latch(24'hFFFFC0);
        check("R2 wrap to entry 1023", int'(sample), 127);
        run_to_latch(24'hFFFFC0);
        check("R2 second step backwards", int'(sample), exp_tab(1022));

        // R6: peak sample 255 gives no high clocks
        do_reset();
        step(1'b1, 1'b1, 24'h400000);
        run_to_latch('0);
        check("R6 peak sample", int'(sample), 255);
        count_high('0, h);
        check("R6 duty at peak", h, 0);

        // R6: trough sample 1 gives 254 high clocks
        do_reset();
        step(1'b1, 1'b1, 24'hC00000);
        run_to_latch('0);
        check("R6 trough sample", int'(sample), 1);
        count_high('0, h);
        check("R6 duty at trough", h, 254);

        // R7: freeze mid-period, then resume
        do_reset();
        for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 24'd192);
        held = sample;
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b0, 24'd192);
            check("R7 frozen pwm", int'(pwm), 0);
            check("R7 frozen sample", int'(sample), int'(held));
        end
        for (int i = 0; i < 600; i++) step(1'b1, 1'b1, 24'd192);

        // R1: reset in the middle of activity
        do_reset();
        check("R1 mid-run reset sample", int'(sample), 128);
        check("R1 mid-run reset pwm", int'(pwm), 0);

        // R5: sweep 512 distinct table entries, step of 3 per period
        for (int p = 0; p < 512; p++) run_to_latch(24'd192);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R3 watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule